// File: doc/BRIEF.md
# Dual-Port Mailbox Doorbell Flags

This block produces one active-low interrupt flag for each of the two ports of a shared dual-port word memory. The two highest word addresses act as doorbells. The second-highest word belongs to port A and the highest word belongs to port B. When one port writes the mailbox of the other port, the other port's flag goes low. The owning port clears its own flag by reading its mailbox. The mailbox words themselves stay ordinary storage in the memory array, which lies outside this block. This block only watches the address and the strobes.

All strobes are sampled on the rising edge of `clk`. Each flag is held by a small two-state machine:

- `FLAG_IDLE`: the flag is high.
- `FLAG_RAISED`: the flag is low.

The transitions are:

- **ring** (`FLAG_IDLE` to `FLAG_RAISED`): a valid write by the peer port.
- **ack** (`FLAG_RAISED` to `FLAG_IDLE`): a read by the owner, when no ring arrives in the same cycle.
- **disable** (`FLAG_RAISED` to `FLAG_IDLE`): `irq_en` is low.

The busy indication from the collision arbiter blocks a ring from a port whose busy is low. When `irq_en` is low, the two mailbox addresses lose their doorbell meaning and both flags stay high.

Top module: `mbx_irq_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released, both `a_irq_n` and `b_irq_n` are 1.
- R2: A port-B write sets `a_irq_n` to 0 on the next rising edge. A port-B write means `b_cs_n`=0, `b_we_n`=0 and `b_busy_n`=1, at address 0x7FFE (the largest address minus one), while `irq_en`=1.
- R3: A port-A write sets `b_irq_n` to 0 on the next rising edge. A port-A write means `a_cs_n`=0, `a_we_n`=0 and `a_busy_n`=1, at address 0x7FFF (the largest address), while `irq_en`=1.
- R4: Port A clears `a_irq_n` to 1 on the next edge with `a_cs_n`=0 and `a_oe_n`=0 at 0x7FFE. The level of `a_we_n` does not matter.
- R5: Port B clears `b_irq_n` to 1 on the next edge with `b_cs_n`=0 and `b_oe_n`=0 at 0x7FFF. The level of `b_we_n` does not matter.
- R6: A mailbox write made while the writing port's busy input is 0 leaves the peer flag unchanged.
- R7: If one port sets a flag and its owner clears it in the same cycle, the flag goes to 0 (the set wins).
- R8: While `irq_en`=0, both flags are 1 on the next edge. Writes made during that time are not remembered once `irq_en` returns to 1.
- R9: No other access changes a flag. This covers other addresses, deselected ports, the owner writing with `oe_n`=1, the peer reading a mailbox, and a port touching its own flag's set address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_en | input | 1 | 1 = mailbox doorbells active |
| a_addr | input | 15 | Port A word address |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_we_n | input | 1 | Port A write strobe, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_busy_n | input | 1 | Port A busy from arbiter, active low |
| b_addr | input | 15 | Port B word address |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_we_n | input | 1 | Port B write strobe, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_busy_n | input | 1 | Port B busy from arbiter, active low |
| a_irq_n | output | 1 | Port A interrupt flag, active low |
| b_irq_n | output | 1 | Port B interrupt flag, active low |

## Verification
Every flag result is due exactly one rising edge after the strobes that cause it, because the only register between the inputs and the outputs is the state of each flag machine. The bench changes inputs on the falling edge and updates its reference model just after the following rising edge. It then compares both flags on the next falling edge, so every comparison sees the result of exactly one sampled cycle. Directed sequences check the set, clear, busy-blocking, set-wins and disable cases with fixed expected values. A long random run, biased toward the mailbox addresses, is compared with the model on every cycle.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    typedef enum logic [0:0] {
        FLAG_IDLE   = 1'b0,
        FLAG_RAISED = 1'b1
    } flag_state_t;

    typedef struct packed {
        logic ring;
        logic ack;
    } flag_req_t;

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int ADDR_W    = 15,
    parameter int OWN_BOX   = 0,
    parameter int PEER_BOX  = 1
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cs_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              busy_n,
    output logic              peer_ring,
    output logic              own_ack
);
    localparam logic [ADDR_W-1:0] OWN_A  = ADDR_W'(OWN_BOX);
    localparam logic [ADDR_W-1:0] PEER_A = ADDR_W'(PEER_BOX);

    logic selected;
    logic hit_own;
    logic hit_peer;

    always_comb begin
        selected  = en && !cs_n;
        hit_own   = (addr == OWN_A);
        hit_peer  = (addr == PEER_A);
        peer_ring = selected && hit_peer && !we_n && busy_n;
        own_ack   = selected && hit_own && !oe_n;
    end
endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  flag_req_t req,
    output logic      irq_n
);
    flag_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE:   if (en && req.ring) state_d = FLAG_RAISED;
            FLAG_RAISED: begin
                if (!en)                         state_d = FLAG_IDLE;
                else if (req.ack && !req.ring)   state_d = FLAG_IDLE;
            end
            default:     state_d = FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        irq_n = (state_q != FLAG_RAISED);
    end

    AST_RING_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req.ring) |=> !irq_n); // R7
    AST_ACK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (en && req.ack && !req.ring) |=> irq_n); // R4
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> irq_n); // R8
    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !req.ring && !req.ack) |=> $stable(irq_n)); // R9
endmodule

// File: rtl/mbx_irq_unit.sv
module mbx_irq_unit
    import mbx_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic              a_cs_n,
    input  logic              a_we_n,
    input  logic              a_oe_n,
    input  logic              a_busy_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic              b_cs_n,
    input  logic              b_we_n,
    input  logic              b_oe_n,
    input  logic              b_busy_n,
    output logic              a_irq_n,
    output logic              b_irq_n
);
    localparam int NPORT  = 2;
    localparam int TOP    = (1 << ADDR_W) - 1;
    localparam int BOX_A  = TOP - 1;
    localparam int BOX_B  = TOP;

    logic [ADDR_W-1:0] addr_v [NPORT];
    logic [NPORT-1:0]  cs_v, we_v, oe_v, busy_v;
    logic [NPORT-1:0]  ring_v, ack_v, irq_v;

    always_comb begin
        addr_v[0] = a_addr;
        addr_v[1] = b_addr;
        cs_v      = {b_cs_n, a_cs_n};
        we_v      = {b_we_n, a_we_n};
        oe_v      = {b_oe_n, a_oe_n};
        busy_v    = {b_busy_n, a_busy_n};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam int OWN  = (p == 0) ? BOX_A : BOX_B;
        localparam int PEER = (p == 0) ? BOX_B : BOX_A;
        flag_req_t req;

        mbx_port_decode #(
            .ADDR_W  (ADDR_W),
            .OWN_BOX (OWN),
            .PEER_BOX(PEER)
        ) u_dec (
            .en       (irq_en),
            .addr     (addr_v[p]),
            .cs_n     (cs_v[p]),
            .we_n     (we_v[p]),
            .oe_n     (oe_v[p]),
            .busy_n   (busy_v[p]),
            .peer_ring(ring_v[p]),
            .own_ack  (ack_v[p])
        );

        always_comb begin
            req.ring = ring_v[NPORT-1-p];
            req.ack  = ack_v[p];
        end

        mbx_flag_fsm u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .en   (irq_en),
            .req  (req),
            .irq_n(irq_v[p])
        );
    end

    assign a_irq_n = irq_v[0];
    assign b_irq_n = irq_v[1];

    AST_A_FALL_NEEDS_FREE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(a_irq_n) |-> $past(!b_cs_n && !b_we_n && b_busy_n && irq_en
                                 && b_addr == ADDR_W'(BOX_A))); // R6
    AST_B_FALL_NEEDS_FREE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(b_irq_n) |-> $past(!a_cs_n && !a_we_n && a_busy_n && irq_en
                                 && a_addr == ADDR_W'(BOX_B))); // R3
    AST_RESET_IDLE: assert property (@(posedge clk)
        !rst_n |-> (a_irq_n && b_irq_n)); // R1
endmodule

// File: tb/sim_mbx_irq_unit.sv
`timescale 1ns/1ps
module sim_mbx_irq_unit;
    localparam int AW = 15;
    localparam logic [AW-1:0] BOX_A = 15'h7FFE;
    localparam logic [AW-1:0] BOX_B = 15'h7FFF;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic irq_en = 1'b1;
    logic [AW-1:0] a_addr = '0, b_addr = '0;
    logic a_cs_n = 1, a_we_n = 1, a_oe_n = 1, a_busy_n = 1;
    logic b_cs_n = 1, b_we_n = 1, b_oe_n = 1, b_busy_n = 1;
    logic a_irq_n, b_irq_n;

    int n_chk = 0;
    int n_fail = 0;
    bit m_a = 1'b1;
    bit m_b = 1'b1;

    always #4 clk = ~clk;

    mbx_irq_unit #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .irq_en(irq_en),
        .a_addr(a_addr), .a_cs_n(a_cs_n), .a_we_n(a_we_n), .a_oe_n(a_oe_n), .a_busy_n(a_busy_n),
        .b_addr(b_addr), .b_cs_n(b_cs_n), .b_we_n(b_we_n), .b_oe_n(b_oe_n), .b_busy_n(b_busy_n),
        .a_irq_n(a_irq_n), .b_irq_n(b_irq_n)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic idle();
        a_cs_n = 1; a_we_n = 1; a_oe_n = 1; a_busy_n = 1; a_addr = '0;
        b_cs_n = 1; b_we_n = 1; b_oe_n = 1; b_busy_n = 1; b_addr = '0;
    endtask

    // Behavioural reference: one cycle of the doorbell rules.
    task automatic model_tick();
        bit ring_a, ring_b, ack_a, ack_b;
        ring_a = irq_en && !b_cs_n && !b_we_n && b_busy_n && (b_addr == BOX_A);
        ring_b = irq_en && !a_cs_n && !a_we_n && a_busy_n && (a_addr == BOX_B);
        ack_a  = irq_en && !a_cs_n && !a_oe_n && (a_addr == BOX_A);
        ack_b  = irq_en && !b_cs_n && !b_oe_n && (b_addr == BOX_B);
        if (!irq_en) begin m_a = 1; m_b = 1; end
        else begin
            if (ring_a) m_a = 0; else if (ack_a) m_a = 1;
            if (ring_b) m_b = 0; else if (ack_b) m_b = 1;
        end
    endtask

    // Inputs already set at a falling edge; advance one cycle and compare.
    task automatic step(input string tag);
        @(posedge clk);
        model_tick();
        @(negedge clk);
        check({tag, " a_irq_n model"}, a_irq_n, m_a);
        check({tag, " b_irq_n model"}, b_irq_n, m_b);
    endtask

    task automatic expect2(input string tag, input logic ea, input logic eb);
        check({tag, " a_irq_n"}, a_irq_n, ea);
        check({tag, " b_irq_n"}, b_irq_n, eb);
    endtask

    task automatic b_write(input logic [AW-1:0] ad, input logic busy);
        b_cs_n = 0; b_we_n = 0; b_oe_n = 1; b_addr = ad; b_busy_n = busy;
    endtask

    task automatic a_write(input logic [AW-1:0] ad, input logic busy);
        a_cs_n = 0; a_we_n = 0; a_oe_n = 1; a_addr = ad; a_busy_n = busy;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        expect2("R1 in reset", 1'b1, 1'b1);
        rst_n = 1'b1;
        step("R1");
        expect2("R1 after reset", 1'b1, 1'b1);

        b_write(BOX_A, 1'b1); step("R2");
        expect2("R2 ring A", 1'b0, 1'b1);
        idle(); step("R9"); expect2("R9 hold", 1'b0, 1'b1);

        a_cs_n = 0; a_oe_n = 0; a_we_n = 1; a_addr = BOX_A; step("R4");
        idle(); expect2("R4 read ack", 1'b1, 1'b1);

        b_write(BOX_A, 1'b1); step("R2"); idle();
        a_cs_n = 0; a_oe_n = 0; a_we_n = 0; a_addr = BOX_A; step("R4");
        idle(); expect2("R4 ack with we low", 1'b1, 1'b1);

        a_write(BOX_B, 1'b1); step("R3"); idle();
        expect2("R3 ring B", 1'b1, 1'b0);
        b_cs_n = 0; b_oe_n = 0; b_addr = BOX_B; step("R5"); idle();
        expect2("R5 ack B", 1'b1, 1'b1);

        b_write(BOX_A, 1'b0); step("R6"); idle();
        expect2("R6 busy blocks A ring", 1'b1, 1'b1);
        a_write(BOX_B, 1'b0); step("R6"); idle();
        expect2("R6 busy blocks B ring", 1'b1, 1'b1);

        b_write(BOX_A, 1'b1); step("R2"); idle();
        b_write(BOX_A, 1'b1);
        a_cs_n = 0; a_oe_n = 0; a_addr = BOX_A; step("R7"); idle();
        expect2("R7 set wins", 1'b0, 1'b1);

        irq_en = 0; step("R8");
        expect2("R8 disable clears", 1'b1, 1'b1);
        b_write(BOX_A, 1'b1); a_write(BOX_B, 1'b1); step("R8"); idle();
        expect2("R8 ring ignored", 1'b1, 1'b1);
        irq_en = 1; step("R8");
        expect2("R8 not remembered", 1'b1, 1'b1);

        b_write(BOX_A, 1'b1); step("R2"); idle();
        a_write(BOX_A, 1'b1); step("R9"); idle();
        expect2("R9 owner write oe high", 1'b0, 1'b1);
        b_cs_n = 0; b_oe_n = 0; b_addr = BOX_A; step("R9"); idle();
        expect2("R9 peer read", 1'b0, 1'b1);
        a_cs_n = 0; a_oe_n = 0; a_addr = BOX_B; step("R9"); idle();
        expect2("R9 A reads B box", 1'b0, 1'b1);
        b_write(15'h7FFD, 1'b1); a_write(15'h0000, 1'b1); step("R9"); idle();
        expect2("R9 other address", 1'b0, 1'b1);
        a_write(BOX_B, 1'b1); a_cs_n = 1; step("R9"); idle();
        expect2("R9 deselected", 1'b0, 1'b1);
        b_write(BOX_B, 1'b1); step("R9"); idle();
        expect2("R9 B writes own box", 1'b0, 1'b1);

        for (int i = 0; i < 3000; i++) begin
            int ra, rb;
            ra = $urandom % 4; rb = $urandom % 4;
            a_addr   = (ra == 0) ? BOX_A : (ra == 1) ? BOX_B : (ra == 2) ? 15'h7FFD : AW'($urandom);
            b_addr   = (rb == 0) ? BOX_A : (rb == 1) ? BOX_B : (rb == 2) ? 15'h7FFD : AW'($urandom);
            a_cs_n   = $urandom % 2; a_we_n = $urandom % 2; a_oe_n = $urandom % 2;
            b_cs_n   = $urandom % 2; b_we_n = $urandom % 2; b_oe_n = $urandom % 2;
            a_busy_n = ($urandom % 4) != 0;
            b_busy_n = ($urandom % 4) != 0;
            irq_en   = ($urandom % 16) != 0;
            step("R9 random");
        end
        summary();
    end
endmodule